// File: doc/BRIEF.md
# Per-Bit Interrupt Distribution Channel

This block turns rising edges on a word of source lines into up to N independent interrupt outputs. Each of the low N source positions owns a status bit, a pending bit and its own output line. A new event on a position is shown to software at once, unless that position is busy or masked. A busy position already has its status bit set. A masked or busy position instead records the event as pending. The event is shown later, when software acknowledges that position.

Software acknowledges positions by writing a word of ones to the clear port. Each named position is either closed, which drops its output, or re-armed from its pending bit, which keeps its output high. A write of all ones is a plain initialisation: it wipes status and touches nothing else. Because every check applies to a single position, one busy position never delays the others. The status word is visible at all times on the read port.

Top module: `irq_perbit_chan`

## Requirements
- R1: After reset the status word, every pending bit and every interrupt output are zero.
- R2: A rising edge on an enabled source line i (i below N) that is unmasked, while status bit i is clear, sets status bit i and raises output i on the following clock edge. Several positions may start in the same cycle.
- R3: A rising edge on an enabled line i that is masked, or whose status bit i is already set, leaves status bit i and output i unchanged and records pending bit i.
- R4: Lines at position N or above, lines whose enable bit is zero, and lines held steadily high cause no change of status or outputs.
- R5: A clear write whose data is neither zero nor all ones clears each named status bit i; where pending bit i is zero, output i drops on the next edge.
- R6: For a named bit i whose pending bit is set, the clear write sets status bit i again, keeps output i high and consumes the pending bit, so a second clear of bit i drops the output.
- R7: A clear write with data zero changes nothing.
- R8: A clear write of all ones (every bit of the full source width set) zeroes the status word, leaves every output at its level and keeps pending bits unpromoted; they are still promoted by a later ordinary clear.
- R9: Outputs and status bits of positions not named in a clear write keep their values.
- R10: A clear of bit i and a new event on line i in the same cycle are resolved clear first, so the event then finds status bit i clear and shows itself at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | SRC_W | Source line levels |
| en_i | input | SRC_W | Per-line enable |
| msk_i | input | SRC_W | Per-line mask (events go pending) |
| clr_we_i | input | 1 | Clear write strobe |
| clr_data_i | input | SRC_W | Clear write data, one bit per position |
| status_o | output | N_OUT | Status read port |
| irq_o | output | N_OUT | One interrupt output per position |

## Verification
The bench builds the block with its defaults, a 32-bit source word and ten outputs. The 32-bit width puts lines 10 through 31 in reach, so the bench can show that enabled high lines outside the output range stay silent. It also makes the all-ones test span the whole word, not just the ten used positions. Ten outputs let the bench hit both ends, position 0 and position 9, and run several positions in parallel. The bench then checks re-arming from pending, the initialisation write and the same-cycle clear-then-event order on a single position.

// File: rtl/irqch_pkg.sv
package irqch_pkg;

    typedef struct packed {
        logic st;
        logic pd;
        logic irq;
    } slot_state_t;

endpackage

// File: rtl/irqch_edge.sv
module irqch_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irqch_clr_decode.sv
module irqch_clr_decode #(
    parameter int W = 32,
    parameter int N = 10
) (
    input  logic         we_i,
    input  logic [W-1:0] data_i,
    output logic         wipe_o,
    output logic [N-1:0] hit_o
);
    logic all_ones, non_zero;

    always_comb begin
        all_ones = &data_i;
        non_zero = |data_i;
        wipe_o   = we_i && all_ones;
        hit_o    = (we_i && non_zero && !all_ones) ? data_i[N-1:0] : '0;
    end
endmodule

// File: rtl/irqch_slot.sv
module irqch_slot
    import irqch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic msk_i,
    input  logic wipe_i,
    input  logic hit_i,
    output logic st_o,
    output logic irq_o
);
    slot_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // acknowledgement is applied before any new event
        if (wipe_i) begin
            s_d.st = 1'b0;
        end else if (hit_i) begin
            if (s_q.pd) begin
                s_d.st  = 1'b1;
                s_d.pd  = 1'b0;
                s_d.irq = 1'b1;
            end else begin
                s_d.st  = 1'b0;
                s_d.irq = 1'b0;
            end
        end
        if (ev_i) begin
            if (msk_i || s_d.st) begin
                s_d.pd = 1'b1;
            end else begin
                s_d.st  = 1'b1;
                s_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_o  = s_q.st;
    assign irq_o = s_q.irq;

    assert_show_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && !msk_i && !s_q.st && !hit_i && !wipe_i |=> s_q.st && s_q.irq);

    assert_hold_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && (msk_i || s_q.st) && !hit_i && !wipe_i
        |=> s_q.pd && (s_q.irq == $past(s_q.irq)) && (s_q.st == $past(s_q.st)));

    assert_close_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i && !s_q.pd && !ev_i |=> !s_q.irq && !s_q.st);

    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i && s_q.pd && !ev_i |=> s_q.st && s_q.irq && !s_q.pd);

    assert_wipe_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i && !ev_i
        |=> !s_q.st && (s_q.irq == $past(s_q.irq)) && (s_q.pd == $past(s_q.pd)));
endmodule

// File: rtl/irq_perbit_chan.sv
module irq_perbit_chan #(
    parameter int SRC_W = 32,
    parameter int N_OUT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic [SRC_W-1:0] en_i,
    input  logic [SRC_W-1:0] msk_i,
    input  logic             clr_we_i,
    input  logic [SRC_W-1:0] clr_data_i,
    output logic [N_OUT-1:0] status_o,
    output logic [N_OUT-1:0] irq_o
);
    localparam int USED = (N_OUT < SRC_W) ? N_OUT : SRC_W;

    logic [SRC_W-1:0] rise;
    logic [N_OUT-1:0] sel;
    logic [N_OUT-1:0] hit;
    logic             wipe;

    irqch_edge #(.W(SRC_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(src_i), .rise_o(rise)
    );

    irqch_clr_decode #(.W(SRC_W), .N(N_OUT)) u_dec (
        .we_i(clr_we_i), .data_i(clr_data_i), .wipe_o(wipe), .hit_o(hit)
    );

    always_comb begin
        sel = '0;
        sel[USED-1:0] = rise[USED-1:0] & en_i[USED-1:0];
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_slot
        if (i < SRC_W) begin : g_live
            irqch_slot u_slot (
                .clk(clk), .rst_n(rst_n),
                .ev_i(sel[i]), .msk_i(msk_i[i]),
                .wipe_i(wipe), .hit_i(hit[i]),
                .st_o(status_o[i]), .irq_o(irq_o[i])
            );
        end else begin : g_dead
            assign status_o[i] = 1'b0;
            assign irq_o[i]    = 1'b0;
        end
    end

    assert_zero_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i && (clr_data_i == '0) && (sel == '0)
        |=> $stable(status_o) && $stable(irq_o));

    assert_irq_needs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) && !clr_we_i |=> $stable(status_o) && $stable(irq_o));
endmodule

// File: tb/tb_irq_perbit_chan.sv
module tb_irq_perbit_chan;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_W = 32;
    localparam int N_OUT = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SRC_W-1:0] src = '0;
    logic [SRC_W-1:0] en = '1;
    logic [SRC_W-1:0] msk = '0;
    logic             we = 1'b0;
    logic [SRC_W-1:0] data = '0;
    logic [N_OUT-1:0] status, irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [N_OUT-1:0] st;
        logic [N_OUT-1:0] irq;
        string            tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_perbit_chan #(.SRC_W(SRC_W), .N_OUT(N_OUT)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .en_i(en), .msk_i(msk),
        .clr_we_i(we), .clr_data_i(data), .status_o(status), .irq_o(irq)
    );

    task automatic cyc(input logic [N_OUT-1:0] es, input logic [N_OUT-1:0] ei,
                       input string tag);
        exp_t e;
        e.st = es; e.irq = ei; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: pops one expectation per clock edge, samples after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (status !== e.st || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: status=%h irq=%h expected status=%h irq=%h",
                         e.tag, status, irq, e.st, e.irq);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(10'h000, 10'h000, "R1 reset state");
        src[0] = 1'b1;
        cyc(10'h001, 10'h001, "R2 event on line 0");
        src[0] = 1'b0;
        cyc(10'h001, 10'h001, "R2 level held");
        src[0] = 1'b1;
        cyc(10'h001, 10'h001, "R3 busy line goes pending");
        src[0] = 1'b0; we = 1'b1; data = 32'h1;
        cyc(10'h001, 10'h001, "R6 pending re-arms line 0");
        cyc(10'h000, 10'h000, "R5 R6 second clear drops line 0");
        we = 1'b0; msk[3] = 1'b1; src[3] = 1'b1;
        cyc(10'h000, 10'h000, "R3 masked line 3 goes pending");
        src[3] = 1'b0; msk[3] = 1'b0;
        src[31] = 1'b1; src[12] = 1'b1; en[5] = 1'b0; src[5] = 1'b1;
        cyc(10'h000, 10'h000, "R4 upper and disabled lines silent");
        en[5] = 1'b1;
        cyc(10'h000, 10'h000, "R4 steady high level silent");
        src = '0; we = 1'b1; data = '0;
        cyc(10'h000, 10'h000, "R7 zero write idle");
        we = 1'b0; src[1] = 1'b1; src[2] = 1'b1;
        cyc(10'h006, 10'h006, "R2 two lines same cycle");
        src = '0; we = 1'b1; data = '0;
        cyc(10'h006, 10'h006, "R7 zero write with status set");
        data = 32'h2;
        cyc(10'h004, 10'h004, "R9 clear of line 1 spares line 2");
        data = '1;
        cyc(10'h000, 10'h004, "R8 all ones wipes status only");
        data = 32'h8;
        cyc(10'h008, 10'h00C, "R8 R6 pending survived wipe and re-arms");
        data = 32'h4;
        cyc(10'h008, 10'h008, "R5 R9 line 2 drops, line 3 kept");
        data = 32'h8; src[3] = 1'b1;
        cyc(10'h008, 10'h008, "R10 clear then event same cycle");
        src = '0;
        cyc(10'h000, 10'h000, "R5 line 3 closed");
        we = 1'b0; src[9] = 1'b1;
        cyc(10'h200, 10'h200, "R2 top position 9");
        src = '0; we = 1'b1; data = 32'h200;
        cyc(10'h000, 10'h000, "R5 top position cleared");
        we = 1'b0;
        cyc(10'h000, 10'h000, "R9 quiet after sequence");
        @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule